// File: doc/BRIEF.md
# DDR2 Power-Down Entry and Exit Scheduler

This block sits next to the command issuer of a DDR2 memory controller and decides when the clock enable pin may fall and when it may rise again. It watches every command the issuer sends: bank activate, read, write, read or write with auto-precharge, single-bank precharge, precharge-all, auto-refresh and mode-register writes. From these it keeps a single countdown. Each command can only lengthen that countdown, never shorten it. The block reports whether entering power-down is legal in the current cycle. It also reports which kind of power-down would result: active if any bank is still open, precharge if all banks are closed.

When the controller asks to enter and entry is legal, the block drops the clock enable output on the next clock edge. When the controller asks to leave, the block raises clock enable on the next edge. It then holds `cmd_allowed` low for an exit delay before any non-NOP command may be issued. For active power-down this delay is a fast or a slow value, chosen by a mode bit. Precharge power-down always uses the fast value.

The command input is only observed and never stalled, so it has no back-pressure. A command counts when `cmd_valid` is high at a rising clock edge. The controller must send only NOPs while `cmd_allowed` is low. All timing parameters are static configuration inputs given in clock cycles. The block samples them on every edge where reset is held and keeps them fixed once reset is released.

Top module: `pd_sched`

## Requirements
- R1: While reset is active and on the first cycle after it, the outputs are cke=1, pd_allowed=1, cmd_allowed=1 and pd_type=0. Here pd_type 1 means active and 0 means precharge.
- R2: pd_type is 1 while at least one bank is open and 0 when none is. Command codes: 1 is activate, which opens the addressed bank. 6 is precharge, which closes the addressed bank. 7 is precharge-all, which closes every bank.
- R3: Read is code 2 and read with auto-precharge is code 3. After either, pd_allowed stays low for AL+CL+BL/2 cycles and is high on the next cycle. BL/2 is 4 when cfg_bl8=1 and 2 otherwise.
- R4: After a write (code 4), pd_allowed stays low for WL+BL/2+tWTR cycles, where WL=AL+CL-1.
- R5: After a write with auto-precharge (code 5), pd_allowed stays low for WL+BL/2+WR cycles. The addressed bank counts as closed from that command, so the resulting mode is precharge.
- R6: A mode-register write (code 9) blocks entry for tMRD cycles. Activate, precharge, precharge-all and auto-refresh (code 8) add no blocking window.
- R7: A command whose window is shorter than the time still remaining does not shorten it.
- R8: A pd_req sampled while pd_allowed is high drives cke low on that edge. A pd_req sampled while pd_allowed is low has no effect.
- R9: A pd_exit sampled in power-down raises cke on that edge. cmd_allowed then stays low for D cycles, counting the cycle in which cke rises. D is cfg_xards for active power-down with cfg_slow_exit=1, and cfg_xard otherwise.
- R10: Configuration inputs are captured while reset is active. Changes after reset is released have no effect.
- R11: Whenever cke is low, or the exit delay is running, both pd_allowed and cmd_allowed are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_code | input | 4 | Command code (see R2 to R6; 0 is NOP) |
| cmd_bank | input | 3 | Bank address of the command |
| cfg_al | input | 4 | Additive latency |
| cfg_cl | input | 4 | CAS latency |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cfg_wr | input | 4 | Write recovery cycles |
| cfg_wtr | input | 4 | Write-to-read delay cycles |
| cfg_mrd | input | 4 | Mode-register set delay cycles |
| cfg_xard | input | 4 | Fast exit delay cycles |
| cfg_xards | input | 4 | Slow exit delay cycles |
| cfg_slow_exit | input | 1 | Selects the slow exit delay for active power-down |
| pd_req | input | 1 | Request to enter power-down |
| pd_exit | input | 1 | Request to leave power-down |
| cke | output | 1 | Clock enable to the memory |
| pd_allowed | output | 1 | Entry is legal this cycle |
| pd_type | output | 1 | 1 means active power-down, 0 means precharge |
| cmd_allowed | output | 1 | Non-NOP commands may be issued |

## Verification
A corrupted countdown shows on pd_allowed within the window of the command that loaded it. The bench counts every cycle of each window, so a window that ends one cycle early or late fails in that same cycle. A stale bank flag shows on pd_type in the cycle right after the command. A wrong power-down mode recorded at entry only appears at exit, as a cmd_allowed low period of the wrong length. A wrong state in the clock enable sequencer shows on cke, or on cmd_allowed, at the first edge after the request.

// File: rtl/pd_sched_pkg.sv
package pd_sched_pkg;
  typedef enum logic [3:0] {
    CMD_NOP  = 4'd0,
    CMD_ACT  = 4'd1,
    CMD_RD   = 4'd2,
    CMD_RDA  = 4'd3,
    CMD_WR   = 4'd4,
    CMD_WRA  = 4'd5,
    CMD_PRE  = 4'd6,
    CMD_PREA = 4'd7,
    CMD_REF  = 4'd8,
    CMD_MRS  = 4'd9
  } cmd_e;

  typedef enum logic [1:0] {
    CK_UP   = 2'd0,
    CK_DOWN = 2'd1,
    CK_EXIT = 2'd2
  } cke_st_e;
endpackage

// File: rtl/pd_window_timer.sv
module pd_window_timer
  import pd_sched_pkg::*;
#(
  parameter int CFG_W = 4,
  parameter int CNT_W = CFG_W + 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_e             cmd,
  input  logic [CFG_W-1:0] al,
  input  logic [CFG_W-1:0] cl,
  input  logic [CFG_W-1:0] wr,
  input  logic [CFG_W-1:0] wtr,
  input  logic [CFG_W-1:0] mrd,
  input  logic             bl8,
  output logic             idle
);
  logic [CNT_W-1:0] rl, wl, half, win, cnt, dec, nxt;

  always_comb begin
    rl   = CNT_W'(al) + CNT_W'(cl);
    wl   = rl - 1'b1;
    half = bl8 ? CNT_W'(4) : CNT_W'(2);
    case (cmd)
      CMD_RD, CMD_RDA: win = rl + half;
      CMD_WR:          win = wl + half + CNT_W'(wtr);
      CMD_WRA:         win = wl + half + CNT_W'(wr);
      CMD_MRS:         win = CNT_W'(mrd);
      default:         win = '0;
    endcase
    dec = (cnt == '0) ? '0 : cnt - 1'b1;
    nxt = (win > dec) ? win : dec;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= nxt;
  end

  assign idle = (cnt == '0);

  // R3
  read_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_RDA) |=> !idle);

  // R7
  no_shorten_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && cmd != CMD_NOP) |=> (cnt >= $past(cnt) - 1'b1));
endmodule

// File: rtl/pd_bank_track.sv
module pd_bank_track
  import pd_sched_pkg::*;
#(
  parameter int BANKS = 8,
  parameter int BA_W  = $clog2(BANKS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  cmd_e            cmd,
  input  logic [BA_W-1:0] bank,
  output logic            any_open
);
  logic [BANKS-1:0] open_q;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic hit;
    assign hit = (bank == BA_W'(b));
    always_ff @(posedge clk) begin
      if (!rst_n) open_q[b] <= 1'b0;
      else if (cmd == CMD_PREA) open_q[b] <= 1'b0;
      else if (hit && cmd == CMD_ACT) open_q[b] <= 1'b1;
      else if (hit && (cmd == CMD_PRE || cmd == CMD_RDA || cmd == CMD_WRA))
        open_q[b] <= 1'b0;
    end
  end

  assign any_open = |open_q;

  // R2
  close_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_PREA) |=> !any_open);

  // R2
  open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_ACT) |=> any_open);
endmodule

// File: rtl/pd_cke_ctrl.sv
module pd_cke_ctrl
  import pd_sched_pkg::*;
#(
  parameter int CFG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             exit_req,
  input  logic             active_now,
  input  logic             slow,
  input  logic [CFG_W-1:0] xard,
  input  logic [CFG_W-1:0] xards,
  output logic             cke,
  output logic             up
);
  cke_st_e          st;
  logic             mode_q;
  logic [CFG_W-1:0] x, dly;

  assign dly = (mode_q && slow) ? xards : xard;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= CK_UP;
      cke    <= 1'b1;
      mode_q <= 1'b0;
      x      <= '0;
    end else begin
      case (st)
        CK_UP: if (go) begin
          st     <= CK_DOWN;
          cke    <= 1'b0;
          mode_q <= active_now;
        end
        CK_DOWN: if (exit_req) begin
          cke <= 1'b1;
          if (dly == '0) st <= CK_UP;
          else begin
            st <= CK_EXIT;
            x  <= dly;
          end
        end
        CK_EXIT: begin
          if (x <= CFG_W'(1)) st <= CK_UP;
          else                x  <= x - 1'b1;
        end
        default: st <= CK_UP;
      endcase
    end
  end

  assign up = (st == CK_UP);

  // R8
  entry_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> $past(go));

  // R9
  exit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == CK_EXIT) |-> (cke && x != '0));

  // R11
  down_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> !up);
endmodule

// File: rtl/pd_sched.sv
module pd_sched
  import pd_sched_pkg::*;
#(
  parameter int BANKS = 8,
  parameter int CFG_W = 4,
  localparam int BA_W = $clog2(BANKS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [3:0]       cmd_code,
  input  logic [BA_W-1:0]  cmd_bank,
  input  logic [CFG_W-1:0] cfg_al,
  input  logic [CFG_W-1:0] cfg_cl,
  input  logic             cfg_bl8,
  input  logic [CFG_W-1:0] cfg_wr,
  input  logic [CFG_W-1:0] cfg_wtr,
  input  logic [CFG_W-1:0] cfg_mrd,
  input  logic [CFG_W-1:0] cfg_xard,
  input  logic [CFG_W-1:0] cfg_xards,
  input  logic             cfg_slow_exit,
  input  logic             pd_req,
  input  logic             pd_exit,
  output logic             cke,
  output logic             pd_allowed,
  output logic             pd_type,
  output logic             cmd_allowed
);
  logic [CFG_W-1:0] al_q, cl_q, wr_q, wtr_q, mrd_q, xard_q, xards_q;
  logic             bl8_q, slow_q;
  cmd_e             cmd_now;
  logic             busy, idle, any_open, up, go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      al_q    <= cfg_al;
      cl_q    <= cfg_cl;
      wr_q    <= cfg_wr;
      wtr_q   <= cfg_wtr;
      mrd_q   <= cfg_mrd;
      xard_q  <= cfg_xard;
      xards_q <= cfg_xards;
      bl8_q   <= cfg_bl8;
      slow_q  <= cfg_slow_exit;
    end
  end

  always_comb begin
    cmd_now = cmd_valid ? cmd_e'(cmd_code) : CMD_NOP;
    busy    = (cmd_now != CMD_NOP);
  end

  pd_window_timer #(.CFG_W(CFG_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_now),
    .al(al_q), .cl(cl_q), .wr(wr_q), .wtr(wtr_q), .mrd(mrd_q),
    .bl8(bl8_q), .idle(idle)
  );

  pd_bank_track #(.BANKS(BANKS)) u_banks (
    .clk(clk), .rst_n(rst_n), .cmd(cmd_now), .bank(cmd_bank),
    .any_open(any_open)
  );

  assign pd_allowed = up && idle && !busy;
  assign go         = pd_req && pd_allowed;

  pd_cke_ctrl #(.CFG_W(CFG_W)) u_cke (
    .clk(clk), .rst_n(rst_n), .go(go), .exit_req(pd_exit),
    .active_now(any_open), .slow(slow_q),
    .xard(xard_q), .xards(xards_q), .cke(cke), .up(up)
  );

  assign cmd_allowed = up;
  assign pd_type     = any_open;

  // R11
  allowed_needs_cke_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pd_allowed |-> (cke && cmd_allowed));
endmodule

// File: tb/pd_sched_test.sv
module pd_sched_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [3:0] cmd_code = 4'd0;
  logic [2:0] cmd_bank = 3'd0;
  logic [3:0] cfg_al, cfg_cl, cfg_wr, cfg_wtr, cfg_mrd, cfg_xard, cfg_xards;
  logic       cfg_bl8, cfg_slow_exit;
  logic       pd_req = 1'b0, pd_exit = 1'b0;
  logic       cke, pd_allowed, pd_type, cmd_allowed;

  int total = 0, bad = 0;
  bit done = 0;
  logic ptype = 1'b0;

  typedef struct {
    string tag;
    logic  allowed, ck, cok, pt;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  pd_sched uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cfg_al(cfg_al), .cfg_cl(cfg_cl), .cfg_bl8(cfg_bl8),
    .cfg_wr(cfg_wr), .cfg_wtr(cfg_wtr), .cfg_mrd(cfg_mrd), .cfg_xard(cfg_xard),
    .cfg_xards(cfg_xards), .cfg_slow_exit(cfg_slow_exit), .pd_req(pd_req),
    .pd_exit(pd_exit), .cke(cke), .pd_allowed(pd_allowed), .pd_type(pd_type),
    .cmd_allowed(cmd_allowed)
  );

  // monitor: compares queued expectations 8 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #8;
      while (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        total++;
        if ({pd_allowed, cke, cmd_allowed, pd_type} !== {e.allowed, e.ck, e.cok, e.pt}) begin
          bad++;
          $display("FAIL %s: allowed/cke/cmd_ok/type actual=%b%b%b%b expected=%b%b%b%b",
                   e.tag, pd_allowed, cke, cmd_allowed, pd_type,
                   e.allowed, e.ck, e.cok, e.pt);
        end
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    #4;
  endtask

  task automatic expect_st(string tag, logic a, logic k, logic c, logic t);
    exp_t e;
    e.tag = tag; e.allowed = a; e.ck = k; e.cok = c; e.pt = t;
    sb.push_back(e);
  endtask

  task automatic issue(logic [3:0] c, logic [2:0] b);
    #8;
    cmd_valid = 1'b1; cmd_code = c; cmd_bank = b;
    @(posedge clk);
    #4;
    cmd_valid = 1'b0; cmd_code = 4'd0;
  endtask

  task automatic window(int w, string tag);
    expect_st(tag, w == 0, 1'b1, 1'b1, ptype);
    for (int k = 1; k <= w; k++) begin
      tick();
      expect_st(tag, k == w, 1'b1, 1'b1, ptype);
    end
  endtask

  task automatic enter_pd(string tag);
    #8; pd_req = 1'b1;
    @(posedge clk); #4; pd_req = 1'b0;
    expect_st(tag, 1'b0, 1'b0, 1'b0, ptype);
  endtask

  task automatic exit_pd(int d, string tag);
    #8; pd_exit = 1'b1;
    @(posedge clk); #4; pd_exit = 1'b0;
    expect_st(tag, 1'b0, 1'b1, 1'b0, ptype);
    for (int k = 1; k <= d; k++) begin
      tick();
      expect_st(tag, k == d, 1'b1, k == d, ptype);
    end
  endtask

  task automatic do_reset(logic [3:0] cl, logic slow);
    cfg_al = 4'd1; cfg_cl = cl; cfg_bl8 = 1'b0; cfg_wr = 4'd3; cfg_wtr = 4'd2;
    cfg_mrd = 4'd2; cfg_xard = 4'd2; cfg_xards = 4'd5; cfg_slow_exit = slow;
    #8; rst_n = 1'b0;
    repeat (3) tick();
    #8; rst_n = 1'b1;
    tick();
    ptype = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset(4'd3, 1'b1);
    // R1: reset state
    expect_st("R1", 1'b1, 1'b1, 1'b1, 1'b0);
    // R10: inputs change after reset, must be ignored
    cfg_cl = 4'd7; cfg_slow_exit = 1'b0; cfg_wtr = 4'd9;

    issue(4'd1, 3'd2); ptype = 1'b1;
    expect_st("R2", 1'b1, 1'b1, 1'b1, 1'b1);
    issue(4'd2, 3'd2);  window(6, "R3");        // 4 + 2
    issue(4'd4, 3'd2);  window(7, "R4");        // 3 + 2 + 2

    // R8: request while blocked is ignored
    issue(4'd4, 3'd2);
    #8; pd_req = 1'b1; @(posedge clk); #4; pd_req = 1'b0;
    expect_st("R8", 1'b0, 1'b1, 1'b1, ptype);
    repeat (5) tick();
    expect_st("R4", 1'b0, 1'b1, 1'b1, ptype);
    tick();
    expect_st("R4", 1'b1, 1'b1, 1'b1, ptype);

    // R8 and R11: active power-down, slow exit (R9)
    enter_pd("R8");
    tick(); expect_st("R11", 1'b0, 1'b0, 1'b0, ptype);
    tick(); expect_st("R11", 1'b0, 1'b0, 1'b0, ptype);
    exit_pd(5, "R9");

    // R7: activate after a write does not shorten the window
    issue(4'd4, 3'd2);
    tick(); tick();
    issue(4'd1, 3'd5);
    window(4, "R7");

    issue(4'd6, 3'd2);
    expect_st("R2", 1'b1, 1'b1, 1'b1, 1'b1);
    issue(4'd7, 3'd0); ptype = 1'b0;
    expect_st("R2", 1'b1, 1'b1, 1'b1, 1'b0);

    issue(4'd1, 3'd1); ptype = 1'b1;
    issue(4'd5, 3'd1); ptype = 1'b0;
    window(8, "R5");                             // 3 + 2 + 3

    issue(4'd9, 3'd0);  window(2, "R6");
    issue(4'd8, 3'd0);  window(0, "R6");

    // precharge power-down uses the fast delay despite slow mode
    enter_pd("R8");
    exit_pd(2, "R9");

    issue(4'd1, 3'd0); ptype = 1'b1;
    issue(4'd2, 3'd0); window(6, "R10");

    // second configuration: CL=5, fast exit
    do_reset(4'd5, 1'b0);
    expect_st("R1", 1'b1, 1'b1, 1'b1, 1'b0);
    issue(4'd1, 3'd3); ptype = 1'b1;
    issue(4'd3, 3'd3); ptype = 1'b0;
    window(8, "R10");                            // 1 + 5 + 2
    issue(4'd1, 3'd4); ptype = 1'b1;
    enter_pd("R8");
    exit_pd(2, "R9");

    tick(); tick();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule